// File: doc/BRIEF.md
# Width-Configurable Asynchronous SRAM Controller

This block lets a synchronous host use an external asynchronous static memory that is built from four byte-wide lanes. The lanes share one 17-bit address bus and one active-low output enable. Each lane has its own active-low chip select and write enable. Through a runtime mode input, the same memory can be organised as 128K x 32, 256K x 16 or 512K x 8. The block turns the host word address into a lane group and a shared address. It spreads write data onto the selected lanes and collects read data back from them.

Each request is taken over a valid/ready handshake and then runs as a fixed sequence of clock cycles. The cycle counts come from parameters that give the clock period and the memory's minimum times in picoseconds, and every minimum is rounded up to whole clocks. Writes happen in the window where chip select and write enable are both low. Output enable stays high for the whole write. The data bus is driven only after the memory has had time to release it, and it stays driven until write enable has risen. Read results come back on a one-cycle response strobe.

Top module: `sram_width_ctrl`

## Requirements
- R1: While reset is low and right after it, all chip selects and write enables are high, output enable is high, the data driver is off, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: Width codes 0 (32-bit) and 3 (reserved) strobe all four lanes. The shared address is host address bits 16:0 and bits 18:17 are ignored. Data byte k travels on lane k.
- R3: Width code 1 (16-bit) strobes lanes 0 and 1 when host address bit 0 is 0, and lanes 2 and 3 when it is 1. The shared address is host bits 17:1. The write half-word goes to both lane pairs. A read returns the pair's 16 bits zero-extended, with the higher lane in bits 15:8.
- R4: Width code 2 (8-bit) strobes only the lane numbered by host address bits 1:0. The shared address is host bits 18:2. A read returns that lane's byte zero-extended.
- R5: A read holds its chip selects low for RD_CYC clocks (4 by default). Output enable goes low from the second of those clocks onward. Data is sampled at the clock edge that ends the window, and `rsp_valid_o` is high for exactly one cycle after that edge.
- R6: A write pulls chip select and write enable low on the same edge. Both stay low for WP_CYC clocks (3 by default) while output enable stays high. Both then rise on the same edge, followed by REC_CYC recovery clocks (1 by default).
- R7: The data driver is on only while output enable is high. It turns on DRV_CYC clocks (2 by default) into the write pulse and stays on through the recovery clocks after write enable has risen.
- R8: The shared address stays constant from the clock where chip select falls until the end of the recovery clocks.
- R9: A request is accepted only when valid and ready are both high. Ready is 0 while a cycle is in progress. Mode, address, data and direction are captured at acceptance, and later changes to these inputs have no effect on the cycle in progress.
- R10: Lanes outside the selected group keep chip select and write enable high. Write enable is low only on lanes whose chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Width code: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = 32-bit |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle, ready to accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW+2 | Host address in units of the selected width |
| req_wdata_i | input | 32 | Write data, right-aligned for the narrow modes |
| rsp_valid_o | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata_o | output | 32 | Read data, zero-extended in the narrow modes |
| mem_addr_o | output | AW | Shared memory address |
| mem_cs_no | output | 4 | Per-lane chip select, active low |
| mem_we_no | output | 4 | Per-lane write enable, active low |
| mem_oe_no | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 32 | Data to the memory |
| mem_dq_i | input | 32 | Data from the memory |
| mem_dq_oe_o | output | 1 | Enable for the data bus driver |

## Verification
A read response and the acceptance of the next request can fall in the same cycle. Ready is back to 1 on the edge that raises `rsp_valid_o`, so the next write can be accepted immediately and drives the bus shortly after the memory has stopped driving it. The bench provokes this case by issuing each new request at the first sampling point where the previous read's response is visible. A memory model judges the outcome. It flags any cycle where the driver is on while output enable is low, checks every strobe window against the expected clock counts, and the read-back data is then compared with a reference built from the lane-mapping rules.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  localparam int NUM_LANES = 4;
  localparam int LANE_W    = 8;
  localparam int DATA_W    = NUM_LANES * LANE_W;

  typedef enum logic [1:0] {
    WM_32  = 2'd0,
    WM_16  = 2'd1,
    WM_8   = 2'd2,
    WM_RSV = 2'd3
  } width_mode_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [NUM_LANES-1:0] lane_sel(input width_mode_e mode,
                                                    input logic [1:0] lo);
    case (mode)
      WM_16:   return lo[0] ? 4'b1100 : 4'b0011;
      WM_8:    return 4'b0001 << lo;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_gather(input width_mode_e mode,
                                                    input logic [1:0] lo,
                                                    input logic [DATA_W-1:0] dq);
    logic [DATA_W-1:0] r;
    case (mode)
      WM_16:   r = {16'h0, lo[0] ? dq[31:16] : dq[15:0]};
      WM_8:    r = {24'h0, dq[8*lo +: 8]};
      default: r = dq;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic [1:0]           mode_i,
  input  logic [AW+1:0]        haddr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [NUM_LANES-1:0] mask_o,
  output logic [AW-1:0]        maddr_o,
  output logic [DATA_W-1:0]    mdata_o
);

  width_mode_e mode;
  assign mode   = width_mode_e'(mode_i);
  assign mask_o = lane_sel(mode, haddr_i[1:0]);

  always_comb begin
    case (mode)
      WM_16:   maddr_o = haddr_i[AW:1];
      WM_8:    maddr_o = haddr_i[AW+1:2];
      default: maddr_o = haddr_i[AW-1:0];
    endcase
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    always_comb begin
      case (mode)
        WM_16:   mdata_o[LANE_W*l +: LANE_W] = wdata_i[LANE_W*(l%2) +: LANE_W];
        WM_8:    mdata_o[LANE_W*l +: LANE_W] = wdata_i[LANE_W-1:0];
        default: mdata_o[LANE_W*l +: LANE_W] = wdata_i[LANE_W*l +: LANE_W];
      endcase
    end
  end

endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 17,
  parameter int RD_CYC  = 4,
  parameter int WP_CYC  = 3,
  parameter int REC_CYC = 1,
  parameter int DRV_CYC = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_we_i,
  input  logic [1:0]           mode_i,
  input  logic [1:0]           lo_i,
  input  logic [NUM_LANES-1:0] mask_i,
  input  logic [AW-1:0]        maddr_i,
  input  logic [DATA_W-1:0]    mdata_i,
  input  logic [DATA_W-1:0]    mem_dq_i,
  output logic                 req_ready_o,
  output logic                 rsp_valid_o,
  output logic [DATA_W-1:0]    rsp_rdata_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [NUM_LANES-1:0] mem_cs_no,
  output logic [NUM_LANES-1:0] mem_we_no,
  output logic                 mem_oe_no,
  output logic [DATA_W-1:0]    mem_dq_o,
  output logic                 mem_dq_oe_o
);

  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), REC_CYC);
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] RD_LAST  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LAST  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] DRV_AT   = CW'(DRV_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WPULSE, S_WREC} state_e;

  state_e      state_q;
  logic [CW-1:0] cnt_q;
  width_mode_e mode_q;
  logic [1:0]  lo_q;

  assign req_ready_o = (state_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      mode_q      <= WM_32;
      lo_q        <= '0;
      mem_addr_o  <= '0;
      mem_cs_no   <= '1;
      mem_we_no   <= '1;
      mem_oe_no   <= 1'b1;
      mem_dq_o    <= '0;
      mem_dq_oe_o <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid_i) begin
            mem_addr_o <= maddr_i;
            mem_dq_o   <= mdata_i;
            mode_q     <= width_mode_e'(mode_i);
            lo_q       <= lo_i;
            cnt_q      <= '0;
            mem_cs_no  <= ~mask_i;
            if (req_we_i) begin
              mem_we_no <= ~mask_i;  // cs and we fall together: memory stays high-Z
              state_q   <= S_WPULSE;
            end else begin
              state_q   <= S_READ;
            end
          end
        end
        S_READ: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == RD_LAST) begin
            rsp_rdata_o <= lane_gather(mode_q, lo_q, mem_dq_i);
            rsp_valid_o <= 1'b1;
            mem_cs_no   <= '1;
            mem_oe_no   <= 1'b1;
            state_q     <= S_IDLE;
          end else if (cnt_q == '0) begin
            mem_oe_no <= 1'b0;  // one clock after cs, driver already off
          end
        end
        S_WPULSE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == DRV_AT) mem_dq_oe_o <= 1'b1;
          if (cnt_q == WP_LAST) begin
            mem_cs_no <= '1;
            mem_we_no <= '1;
            cnt_q     <= '0;
            state_q   <= S_WREC;
          end
        end
        S_WREC: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == REC_LAST) begin
            mem_dq_oe_o <= 1'b0;
            state_q     <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_we_inside_cs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~mem_we_no) & mem_cs_no) == '0);

  assert_lane_group_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~mem_cs_no) inside {4'b0000, 4'b1111, 4'b0011, 4'b1100,
                         4'b0001, 4'b0010, 4'b0100, 4'b1000});

  assert_no_contention_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  assert_drive_past_we_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(&mem_we_no) |-> mem_dq_oe_o);

  assert_oe_read_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (&mem_we_no));

  assert_rsp_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(~mem_cs_no)) && $past(|(~mem_cs_no))) |-> $stable(mem_addr_o));

  assert_busy_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~mem_cs_no)) |-> !req_ready_o);

endmodule

// File: rtl/sram_width_ctrl.sv
module sram_width_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int CLK_PS    = 5000,
  parameter int T_RC_PS   = 20000,
  parameter int T_AA_PS   = 20000,
  parameter int T_OE_PS   = 9000,
  parameter int T_WP_PS   = 15000,
  parameter int T_WC_PS   = 20000,
  parameter int T_WR_PS   = 5000,
  parameter int T_OHZ_PS  = 9000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW+1:0] req_addr_i,
  input  logic [31:0]   req_wdata_i,
  output logic          rsp_valid_o,
  output logic [31:0]   rsp_rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_cs_no,
  output logic [3:0]    mem_we_no,
  output logic          mem_oe_no,
  output logic [31:0]   mem_dq_o,
  input  logic [31:0]   mem_dq_i,
  output logic          mem_dq_oe_o
);

  localparam int RD_CYC  = imax(imax(cdiv(T_RC_PS, CLK_PS), cdiv(T_AA_PS, CLK_PS)),
                                imax(cdiv(T_OE_PS, CLK_PS) + 1, 2));
  localparam int DRV_CYC = imax(1, cdiv(T_OHZ_PS, CLK_PS));
  localparam int WP_CYC  = imax(cdiv(T_WP_PS, CLK_PS), DRV_CYC + 1);
  localparam int REC_CYC = imax(imax(1, cdiv(T_WR_PS, CLK_PS)),
                                cdiv(T_WC_PS, CLK_PS) - WP_CYC);

  logic [NUM_LANES-1:0] mask;
  logic [AW-1:0]        maddr;
  logic [DATA_W-1:0]    mdata;

  sram_lane_map #(.AW(AW)) u_map (
    .mode_i  (mode_i),
    .haddr_i (req_addr_i),
    .wdata_i (req_wdata_i),
    .mask_o  (mask),
    .maddr_o (maddr),
    .mdata_o (mdata)
  );

  sram_cycle_fsm #(
    .AW      (AW),
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .DRV_CYC (DRV_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .mode_i      (mode_i),
    .lo_i        (req_addr_i[1:0]),
    .mask_i      (mask),
    .maddr_i     (maddr),
    .mdata_i     (mdata),
    .mem_dq_i    (mem_dq_i),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .mem_addr_o  (mem_addr_o),
    .mem_cs_no   (mem_cs_no),
    .mem_we_no   (mem_we_no),
    .mem_oe_no   (mem_oe_no),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
  );

endmodule

// File: tb/sram_width_ctrl_tb.sv
`timescale 1ns/1ps
module sram_width_ctrl_tb;

  localparam int AW  = 17;
  localparam int RDC = 4;
  localparam int WPC = 3;
  localparam int DRV = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode_i = '0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic          req_we_i = 1'b0;
  logic [AW+1:0] req_addr_i = '0;
  logic [31:0]   req_wdata_i = '0;
  logic          rsp_valid_o;
  logic [31:0]   rsp_rdata_o;
  logic [AW-1:0] mem_addr_o;
  logic [3:0]    mem_cs_no, mem_we_no;
  logic          mem_oe_no;
  logic [31:0]   mem_dq_o;
  logic [31:0]   mem_dq_i = '0;
  logic          mem_dq_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sram_width_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o), .req_we_i(req_we_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .mem_addr_o(mem_addr_o), .mem_cs_no(mem_cs_no), .mem_we_no(mem_we_no),
    .mem_oe_no(mem_oe_no), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
    .mem_dq_oe_o(mem_dq_oe_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- memory model with strobe timing checks ----------------
  logic [7:0]  lane_mem [int];
  int          wcnt [4];
  int          rcnt [4];
  int          oecnt[4];
  int          drv_at[4];
  logic [3:0]  prev_act = '0;
  logic [3:0]  last_mask = '0;
  logic [16:0] last_addr = '0;
  logic [16:0] cap_addr = '0;

  initial for (int l = 0; l < 4; l++) begin
    wcnt[l] = 0; rcnt[l] = 0; oecnt[l] = 0; drv_at[l] = -1;
  end

  function automatic logic [7:0] mem_rd(input int key);
    return lane_mem.exists(key) ? lane_mem[key] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (rst_ni) begin
      logic [3:0] act;
      act = ~mem_cs_no;
      if (act != 0 && prev_act == 0) begin
        last_mask = act; last_addr = mem_addr_o; cap_addr = mem_addr_o;
      end
      if (mem_dq_oe_o && !mem_oe_no)
        chk(0, "R7 driver on while output enable low", 1, 0);
      if (act != 0 && mem_addr_o != cap_addr)
        chk(0, "R8 address moved under chip select", 32'(mem_addr_o), 32'(cap_addr));
      for (int l = 0; l < 4; l++) begin
        if (!mem_cs_no[l] && !mem_we_no[l]) begin
          if (mem_dq_oe_o && drv_at[l] < 0) drv_at[l] = wcnt[l];
          if (mem_dq_oe_o) lane_mem[l*131072 + int'(mem_addr_o)] = mem_dq_o[8*l +: 8];
          wcnt[l]++;
        end else if (wcnt[l] > 0) begin
          chk(wcnt[l] == WPC, "R6 write pulse length", wcnt[l], WPC);
          chk(mem_cs_no[l] && mem_we_no[l] && mem_oe_no, "R6 strobes high in recovery",
              {mem_cs_no[l], mem_we_no[l], mem_oe_no}, 3'b111);
          chk(drv_at[l] == DRV, "R7 driver onset", drv_at[l], DRV);
          chk(mem_dq_oe_o, "R7 driver held after we rise", mem_dq_oe_o, 1);
          chk(mem_addr_o == cap_addr, "R8 address held in recovery", 32'(mem_addr_o),
              32'(cap_addr));
          wcnt[l] = 0; drv_at[l] = -1;
        end
        if (!mem_cs_no[l] && mem_we_no[l]) begin
          rcnt[l]++;
          if (!mem_oe_no) oecnt[l]++;
        end else if (rcnt[l] > 0) begin
          chk(rcnt[l] == RDC, "R5 read cs window", rcnt[l], RDC);
          chk(oecnt[l] == RDC - 1, "R5 read oe window", oecnt[l], RDC - 1);
          rcnt[l] = 0; oecnt[l] = 0;
        end
        mem_dq_i[8*l +: 8] <= (!mem_cs_no[l] && !mem_oe_no && mem_we_no[l]) ?
                               mem_rd(l*131072 + int'(mem_addr_o)) : 8'h00;
      end
      prev_act = act;
    end
  end

  // ---------------- reference from the requirements ----------------
  logic [7:0] ref_mem [int];

  function automatic logic [3:0] exp_mask(input logic [1:0] m, input logic [18:0] a);
    if (m == 2'd1) return a[0] ? 4'b1100 : 4'b0011;
    if (m == 2'd2) return 4'b0001 << a[1:0];
    return 4'b1111;
  endfunction

  function automatic logic [16:0] exp_saddr(input logic [1:0] m, input logic [18:0] a);
    if (m == 2'd1) return a[17:1];
    if (m == 2'd2) return a[18:2];
    return a[16:0];
  endfunction

  function automatic logic [7:0] ref_rd(input int l, input logic [16:0] s);
    int key;
    key = l*131072 + int'(s);
    return ref_mem.exists(key) ? ref_mem[key] : 8'h00;
  endfunction

  task automatic ref_write(input logic [1:0] m, input logic [18:0] a, input logic [31:0] d);
    logic [3:0] mk;
    logic [16:0] s;
    mk = exp_mask(m, a); s = exp_saddr(m, a);
    for (int l = 0; l < 4; l++) if (mk[l]) begin
      if (m == 2'd1)      ref_mem[l*131072 + int'(s)] = d[8*(l%2) +: 8];
      else if (m == 2'd2) ref_mem[l*131072 + int'(s)] = d[7:0];
      else                ref_mem[l*131072 + int'(s)] = d[8*l +: 8];
    end
  endtask

  function automatic logic [31:0] ref_read(input logic [1:0] m, input logic [18:0] a);
    logic [16:0] s;
    s = exp_saddr(m, a);
    if (m == 2'd1) begin
      if (a[0]) return {16'h0, ref_rd(3, s), ref_rd(2, s)};
      return {16'h0, ref_rd(1, s), ref_rd(0, s)};
    end
    if (m == 2'd2) return {24'h0, ref_rd(int'(a[1:0]), s)};
    return {ref_rd(3, s), ref_rd(2, s), ref_rd(1, s), ref_rd(0, s)};
  endfunction

  function automatic string mtag(input logic [1:0] m);
    if (m == 2'd1) return "R3";
    if (m == 2'd2) return "R4";
    return "R2";
  endfunction

  // caller is at a negedge; returns at a negedge with ready high
  task automatic op(input bit we, input logic [1:0] m, input logic [18:0] a,
                    input logic [31:0] d);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1; req_we_i = we; mode_i = m; req_addr_i = a; req_wdata_i = d;
    @(negedge clk);
    req_valid_i = 1'b0;
    // R9: scramble captured inputs during the cycle
    req_we_i = ~we; mode_i = 2'($urandom); req_addr_i = 19'($urandom);
    req_wdata_i = $urandom;
    chk(!req_ready_o, "R9 ready low while busy", req_ready_o, 0);
    if (we) begin
      ref_write(m, a, d);
      while (!req_ready_o) @(negedge clk);
      chk(!rsp_valid_o, "R9 no response for a write", rsp_valid_o, 0);
    end else begin
      while (!rsp_valid_o) @(negedge clk);
      chk(rsp_rdata_o == ref_read(m, a), {mtag(m), " read data"}, rsp_rdata_o,
          ref_read(m, a));
    end
    chk(last_mask == exp_mask(m, a), {mtag(m), " R10 lane group"}, 32'(last_mask),
        32'(exp_mask(m, a)));
    chk(last_addr == exp_saddr(m, a), {mtag(m), " shared address"}, 32'(last_addr),
        32'(exp_saddr(m, a)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(mem_cs_no == 4'hF && mem_we_no == 4'hF && mem_oe_no && !mem_dq_oe_o,
        "R1 strobes idle after reset", {mem_cs_no, mem_we_no, mem_oe_no, mem_dq_oe_o},
        {4'hF, 4'hF, 1'b1, 1'b0});
    chk(req_ready_o && !rsp_valid_o, "R1 handshake idle after reset",
        {req_ready_o, rsp_valid_o}, 2'b10);

    // R2: 32-bit write, alias through ignored high bits, reserved code
    op(1, 2'd0, 19'h60005, 32'hA1B2C3D4);
    op(0, 2'd0, 19'h00005, 0);
    op(0, 2'd3, 19'h20005, 0);
    // R4: byte reads of the same word; top lane at the highest address
    for (int l = 0; l < 4; l++) op(0, 2'd2, {17'h00005, 2'(l)}, 0);
    op(1, 2'd2, 19'h7FFFF, 32'hFFFFFF5E);
    op(0, 2'd0, 19'h1FFFF, 0);
    // R3: half-word pairs, upper pair then lower pair
    op(1, 2'd1, 19'h0000B, 32'hDEAD9876);
    op(1, 2'd1, 19'h0000A, 32'h00001234);
    op(0, 2'd1, 19'h0000B, 0);
    op(0, 2'd0, 19'h00005, 0);
    // read response then write accepted in the same cycle, then read back
    op(0, 2'd0, 19'h00005, 0);
    op(1, 2'd0, 19'h00006, 32'h0BADF00D);
    op(0, 2'd2, 19'h0001B, 0);

    for (int i = 0; i < 400; i++) begin
      logic [1:0]  m;
      logic [18:0] a;
      m = 2'($urandom);
      a = 19'($urandom) & 19'h6003F;
      op(bit'($urandom), m, a, $urandom);
    end

    repeat (4) @(negedge clk);
    chk(mem_cs_no == 4'hF && !mem_dq_oe_o, "R1 idle after traffic",
        {mem_cs_no, mem_dq_oe_o}, {4'hF, 1'b0});
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule